// File: doc/BRIEF.md
# Processor Status Flag Register with Bit Set/Clear

This block keeps the eight-bit status register of a small processor core and carries out the single-flag set and clear instructions on it. Each cycle the pipeline may offer one 16-bit instruction word with a valid strobe. When the word is one of the two flag-control forms, the block forces the selected flag to 1 or to 0. The other flags keep their values. All per-flag mnemonics, such as "set carry" or "disable interrupts", are encodings of these two forms with a fixed index.

A second input carries flag results from the arithmetic unit. A per-bit write mask chooses which flags those results overwrite. Both sources may act in the same cycle: the instruction owns its selected bit, and the arithmetic write fills in the rest of its mask. The full register is driven out, along with an interrupt-enable line taken from the top flag.

The instruction input follows valid/ready rules. The block never applies back-pressure, so ready is high whenever reset is released. A word is consumed on any rising edge where valid and ready are both high. Its effect shows in the register output after that edge. The flag-write port is a plain control input and has no handshake.

Top module: `flag_reg_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first update, all eight flags read 0. The flag positions from bit 7 down to bit 0 are: interrupt enable, transfer, half carry, sign, overflow, negative, zero, carry.
- R2: A consumed word of the form 1001_0100_0sss_1000 (binary, s = bits 6..4) sets flag s to 1 at the next rising edge.
- R3: A consumed word of the form 1001_0100_1sss_1000 (bit 7 = 1 selects clear) clears flag s to 0 at the next rising edge.
- R4: A set or clear instruction leaves all seven unselected flags unchanged when no arithmetic write is masked in.
- R5: The interrupt-enable output equals flag bit 7. It goes high after a set with s = 7 and low after a clear with s = 7.
- R6: For each bit whose write-mask bit is 1, the flag takes the matching arithmetic flag input at the next edge. Bits whose mask bit is 0 keep their value.
- R7: If an instruction and a masked arithmetic write arrive in the same cycle, bit s follows the instruction. Every other masked bit follows the arithmetic input.
- R8: A word that matches neither form, or any word presented with valid low, changes no flag.
- R9: The ready output is 1 whenever reset is released and 0 during reset, so one instruction is consumed every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction word is offered |
| ins_ready | output | 1 | Block accepts the instruction word |
| ins_word | input | 16 | Instruction word |
| alu_mask | input | 8 | Per-bit write enable for arithmetic flags |
| alu_flags | input | 8 | Flag values from the arithmetic unit |
| flags_q | output | 8 | Current status register |
| irq_enable | output | 1 | Global interrupt enable (flag bit 7) |

## Verification
The hardest case to produce is an instruction and an arithmetic write landing on the same edge with overlapping bits. In that case the priority decides bit s while the neighbouring masked bits must still take the arithmetic values. The vector table places such collisions deliberately, with the arithmetic value for bit s chosen opposite to what the instruction sets. This makes a wrong priority visible. Near-miss words, valid-low words, and a full sweep of all eight indices in both directions show that only the addressed flag ever moves.

// File: rtl/flag_reg_pkg.sv
package flag_reg_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned IDX_W  = $clog2(FLAG_W);
  localparam int unsigned WORD_W = 16;

  // fixed parts of the flag-control opcode
  localparam logic [7:0] OPC_HIGH = 8'h94;
  localparam logic [3:0] OPC_LOW  = 4'h8;
  localparam int unsigned IDX_LSB = 4;
  localparam int unsigned DIR_BIT = 7;

  typedef enum logic [IDX_W-1:0] {
    FL_CARRY = 3'd0,
    FL_ZERO  = 3'd1,
    FL_NEG   = 3'd2,
    FL_OVF   = 3'd3,
    FL_SIGN  = 3'd4,
    FL_HALF  = 3'd5,
    FL_XFER  = 3'd6,
    FL_IEN   = 3'd7
  } flag_idx_e;

  typedef struct packed {
    logic              hit;
    logic              value;
    logic [FLAG_W-1:0] sel;
  } flag_cmd_t;
endpackage

// File: rtl/flag_cmd_decode.sv
module flag_cmd_decode
  import flag_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] word,
  output flag_cmd_t         cmd
);
  logic              match;
  logic [IDX_W-1:0]  idx;
  logic [FLAG_W-1:0] onehot;

  assign match = (word[15:8] == OPC_HIGH) && (word[3:0] == OPC_LOW);
  assign idx   = word[IDX_LSB +: IDX_W];

  generate
    for (genvar g = 0; g < FLAG_W; g++) begin : g_sel
      assign onehot[g] = (idx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    cmd.hit   = fire && match;
    cmd.value = ~word[DIR_BIT];
    cmd.sel   = cmd.hit ? onehot : '0;
  end

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd.sel));
  p_miss_no_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire || !match) |-> (cmd.sel == '0));
endmodule

// File: rtl/flag_next_merge.sv
module flag_next_merge
  import flag_reg_pkg::*;
(
  input  flag_cmd_t         cmd,
  input  logic [FLAG_W-1:0] cur,
  input  logic [FLAG_W-1:0] alu_mask,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic [FLAG_W-1:0] nxt
);
  generate
    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      always_comb begin
        if (cmd.sel[b])       nxt[b] = cmd.value;
        else if (alu_mask[b]) nxt[b] = alu_flags[b];
        else                  nxt[b] = cur[b];
      end
    end
  endgenerate
endmodule

// File: rtl/flag_reg_top.sv
module flag_reg_top
  import flag_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [WORD_W-1:0] ins_word,
  input  logic [FLAG_W-1:0] alu_mask,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic [FLAG_W-1:0] flags_q,
  output logic              irq_enable
);
  flag_cmd_t         cmd;
  logic [FLAG_W-1:0] flags_d;
  logic              fire;

  assign ins_ready = rst_n;
  assign fire      = ins_valid && ins_ready;

  flag_cmd_decode u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (fire),
    .word (ins_word),
    .cmd  (cmd)
  );

  flag_next_merge u_merge (
    .cmd      (cmd),
    .cur      (flags_q),
    .alu_mask (alu_mask),
    .alu_flags(alu_flags),
    .nxt      (flags_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign irq_enable = flags_q[FL_IEN];

  generate
    for (genvar b = 0; b < FLAG_W; b++) begin : g_chk
      p_set_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.sel[b] && cmd.value) |=> flags_q[b]);
      p_clr_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.sel[b] && !cmd.value) |=> !flags_q[b]);
      p_hold_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd.sel[b] && !alu_mask[b]) |=> $stable(flags_q[b]));
      p_alu_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd.sel[b] && alu_mask[b]) |=> (flags_q[b] == $past(alu_flags[b])));
    end
  endgenerate
endmodule

// File: tb/sim_flag_reg_top.sv
module sim_flag_reg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [15:0] ins_word = '0;
  logic [7:0]  alu_mask = '0;
  logic [7:0]  alu_flags = '0;
  logic [7:0]  flags_q;
  logic        irq_enable;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flag_reg_top u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .alu_mask(alu_mask), .alu_flags(alu_flags),
    .flags_q(flags_q), .irq_enable(irq_enable)
  );

  // {valid, word, mask, alu flags, expected flags after the edge}
  localparam int NV = 16;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 16'h9408, 8'h00, 8'h00, 8'h01},  // R2 set C
    {1'b1, 16'h9478, 8'h00, 8'h00, 8'h81},  // R2 R5 set I
    {1'b1, 16'h9438, 8'h00, 8'h00, 8'h89},  // R2 R4 set V
    {1'b1, 16'h9488, 8'h00, 8'h00, 8'h88},  // R3 clear C
    {1'b1, 16'h0000, 8'h0F, 8'h05, 8'h85},  // R6 masked write
    {1'b1, 16'h9409, 8'h00, 8'h00, 8'h85},  // R8 near miss low nibble
    {1'b0, 16'h94F8, 8'h00, 8'h00, 8'h85},  // R8 valid low
    {1'b1, 16'h94F8, 8'h00, 8'h00, 8'h05},  // R3 R5 clear I
    {1'b1, 16'h9418, 8'h03, 8'h00, 8'h06},  // R7 set Z vs alu 0
    {1'b1, 16'h94A8, 8'h04, 8'hFF, 8'h02},  // R7 clear N vs alu 1
    {1'b1, 16'h9508, 8'h00, 8'h00, 8'h02},  // R8 near miss high byte
    {1'b1, 16'h0000, 8'hFF, 8'hA5, 8'hA5},  // R6 full write
    {1'b1, 16'h9468, 8'h00, 8'h00, 8'hE5},  // R2 set T
    {1'b1, 16'h94D8, 8'h00, 8'h00, 8'hC5},  // R3 clear H
    {1'b1, 16'h0000, 8'h00, 8'h00, 8'hC5},  // R8 no-op word
    {1'b1, 16'h9448, 8'h00, 8'h00, 8'hD5}   // R2 set S
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] w, input logic [7:0] m,
                      input logic [7:0] f);
    ins_valid = v; ins_word = w; alu_mask = m; alu_flags = f;
    @(negedge clk);
    ins_valid = 1'b0; ins_word = '0; alu_mask = '0; alu_flags = '0;
  endtask

  initial begin
    logic [7:0] model;
    @(negedge clk);
    check8("R1", flags_q, 8'h00);
    check8("R9", {7'd0, ins_ready}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R1", flags_q, 8'h00);
    check8("R9", {7'd0, ins_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][40], VEC[i][39:24], VEC[i][23:16], VEC[i][15:8]);
      check8($sformatf("R2-8 vec%0d", i), flags_q, VEC[i][7:0]);
      check8("R5", {7'd0, irq_enable}, {7'd0, VEC[i][7]});
    end

    // reset mid-run clears everything (R1)
    rst_n = 1'b0;
    @(negedge clk);
    check8("R1", flags_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep all indices: set then clear, one flag at a time (R2 R3 R4)
    model = 8'h00;
    for (int s = 0; s < 8; s++) begin
      step(1'b1, {8'h94, 1'b0, 3'(s), 4'h8}, 8'h00, 8'h00);
      model[s] = 1'b1;
      check8("R2 R4 sweep", flags_q, model);
    end
    for (int s = 0; s < 8; s++) begin
      step(1'b1, {8'h94, 1'b1, 3'(s), 4'h8}, 8'h00, 8'h00);
      model[s] = 1'b0;
      check8("R3 R4 sweep", flags_q, model);
    end
    check8("R5", {7'd0, irq_enable}, 8'h00);
    check8("R9", {7'd0, ins_ready}, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule